// File: doc/BRIEF.md
# Scroll and Video Address Counters

This block keeps the scroll position of a tile-based video generator. It stores a live counter set and a staged copy of that set. The live set has a fine row counter (3 bits), a vertical table-select bit, a horizontal table-select bit, a coarse row counter (5 bits) and a coarse column counter (5 bits). A separate 3-bit fine horizontal scroll value sits beside them. Register logic outside the block loads the staged copy. Rendering timing outside the block sends single-cycle strobes that step the live counters or copy staged fields into them.

From the live set the block forms four addresses: tile-name fetch, attribute fetch, pattern fetch and CPU data-port access. The pattern address also uses a tile index and a pattern-bank bit that come from outside. The counters step in three ways. A column step advances one tile to the right. A row step advances one pixel line down. A data-port step moves the whole set as a single counter, by 1 or by 32.

Top module: `scroll_ctr_unit`

## Requirements
- R1: After reset all live fields, all staged fields and the fine horizontal scroll are zero. So nt_addr = 0x2000, at_addr = 0x23C0, port_addr = 0 and pt_addr = {bg_sel, tile_idx, 0, 000}.
- R2: A step_h pulse adds 1 to the 6-bit chain {H, HT}. When HT is 31 it wraps to 0 and H toggles. FV, V and VT do not change.
- R3: A step_v pulse adds 1 to FV. When FV is 7 it wraps to 0 and VT advances. If VT was 29, VT becomes 0 and V toggles. If VT was 31, VT becomes 0 and V does not change. If VT was 30, VT becomes 31. H and HT do not change.
- R4: A step_port pulse with port_by32 = 0 adds 1 to the 15-bit value {FV, V, H, VT, HT}, with HT as the least significant field.
- R5: A step_port pulse with port_by32 = 1 leaves HT unchanged and adds 1 to the 10-bit value {FV, V, H, VT}.
- R6: nt_addr = 0x2000 | V<<11 | H<<10 | VT<<5 | HT, and at_addr = 0x2000 | V<<11 | H<<10 | 0x3C0 | VT[4:2]<<3 | HT[4:2].
- R7: port_addr = FV[1:0]<<12 | V<<11 | H<<10 | VT<<5 | HT, and pt_addr = bg_sel<<12 | tile_idx<<4 | FV, with bit 3 zero.
- R8: tmp_wr loads the staged set from tmp_in, packed as [14:12] FV, [11] V, [10] H, [9:5] VT, [4:0] HT. copy_all loads all five live fields from the staged set. copy_h loads only HT and H, and leaves FV, V and VT unchanged.
- R9: tmp_clr zeroes the staged set and the fine horizontal scroll. It takes precedence over tmp_wr and fh_wr in the same cycle.
- R10: Strobes in one cycle resolve as copy_all, then copy_h, then step_port, then the column and row steps. A higher strobe suppresses every step below it. step_h and step_v together both take effect.
- R11: fh_wr loads fh_in into the fine horizontal scroll, which appears on fine_h on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmp_wr | input | 1 | Load the staged set from tmp_in |
| tmp_in | input | 15 | Staged set value {FV, V, H, VT, HT} |
| fh_wr | input | 1 | Load the fine horizontal scroll |
| fh_in | input | 3 | Fine horizontal scroll value |
| tmp_clr | input | 1 | Zero the staged set and the fine horizontal scroll |
| copy_all | input | 1 | Copy the whole staged set into the live set |
| copy_h | input | 1 | Copy staged HT and H into the live set |
| step_h | input | 1 | Column step |
| step_v | input | 1 | Row step |
| step_port | input | 1 | Data-port step |
| port_by32 | input | 1 | Data-port step size: 0 steps by 1, 1 steps by 32 |
| bg_sel | input | 1 | Pattern bank select |
| tile_idx | input | 8 | Tile index used for the pattern fetch |
| nt_addr | output | 14 | Tile-name fetch address |
| at_addr | output | 14 | Attribute fetch address |
| pt_addr | output | 14 | Pattern fetch address |
| port_addr | output | 14 | Data-port access address |
| fine_h | output | 3 | Fine horizontal scroll |

## Verification
The bench targets the three coarse-row endings. The row before the wrap point, if mishandled, would stop at 30 or leave the vertical table bit unchanged. The top row, if mishandled, would toggle the table bit or stick at 31. Row 30, if mishandled, would jump back to 0. Data-port carries are driven across every field boundary, up to the all-ones rollover. The bench also covers the step-by-32 case, where a design that clocks HT would move the column. Mixed strobes in one cycle check that a copy wins over the steps and that copy_h leaves the vertical fields alone. A clear given in the same cycle as staged writes must win, or stale values would reach the live set on the next copy.

// File: rtl/scrl_pkg.sv
package scrl_pkg;
   localparam int CW = 5;
   localparam int FW = 3;
   localparam int SW = FW + 2 + 2 * CW;
   localparam int AW = 2 * CW + 4;

   // Packed order is also the carry order of the data-port chain (lsb first).
   typedef struct packed {
      logic [FW-1:0] fv;
      logic          vs;
      logic          hs;
      logic [CW-1:0] cv;
      logic [CW-1:0] ch;
   } scrl_set_t;
endpackage

// File: rtl/scrl_hchain.sv
module scrl_hchain
   import scrl_pkg::*;
(
   input  scrl_set_t cur,
   output scrl_set_t nxt
);
   logic [CW:0] sum6;

   always_comb begin
      sum6   = {cur.hs, cur.ch} + {{CW{1'b0}}, 1'b1};
      nxt    = cur;
      nxt.hs = sum6[CW];
      nxt.ch = sum6[CW-1:0];
   end
endmodule

// File: rtl/scrl_vchain.sv
module scrl_vchain
   import scrl_pkg::*;
#(
   parameter int ROW_WRAP = 30
) (
   input  scrl_set_t cur,
   output scrl_set_t nxt
);
   logic [FW:0] fsum;
   assign fsum = {1'b0, cur.fv} + {{FW{1'b0}}, 1'b1};

   generate
      if (ROW_WRAP == (1 << CW)) begin : g_full
         logic [CW:0] rsum;
         always_comb begin
            rsum   = {1'b0, cur.cv} + {{CW{1'b0}}, fsum[FW]};
            nxt    = cur;
            nxt.fv = fsum[FW-1:0];
            nxt.cv = rsum[CW-1:0];
            nxt.vs = cur.vs ^ rsum[CW];
         end
      end else begin : g_short
         always_comb begin
            nxt    = cur;
            nxt.fv = fsum[FW-1:0];
            if (fsum[FW]) begin
               if (cur.cv == CW'(ROW_WRAP - 1)) begin
                  nxt.cv = '0;
                  nxt.vs = ~cur.vs;
               end else begin
                  nxt.cv = cur.cv + 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/scrl_portinc.sv
module scrl_portinc
   import scrl_pkg::*;
(
   input  scrl_set_t cur,
   input  logic      by32,
   output scrl_set_t nxt
);
   logic [SW-1:0]    flat;
   logic [SW-1:0]    inc1;
   logic [SW-CW-1:0] hi_inc;

   always_comb begin
      flat   = cur;
      inc1   = flat + {{(SW-1){1'b0}}, 1'b1};
      hi_inc = flat[SW-1:CW] + {{(SW-CW-1){1'b0}}, 1'b1};
      nxt    = by32 ? scrl_set_t'({hi_inc, flat[CW-1:0]}) : scrl_set_t'(inc1);
   end
endmodule

// File: rtl/scrl_addrgen.sv
module scrl_addrgen
   import scrl_pkg::*;
#(
   parameter int          TILE_W   = 8,
   parameter logic [13:0] NT_BASE  = 14'h2000,
   parameter logic [9:0]  ATTR_OFS = 10'h3C0
) (
   input  scrl_set_t         cur,
   input  logic              bg_sel,
   input  logic [TILE_W-1:0] tile_idx,
   output logic [AW-1:0]     nt_addr,
   output logic [AW-1:0]     at_addr,
   output logic [AW-1:0]     pt_addr,
   output logic [AW-1:0]     port_addr
);
   localparam int TSEL = 2 * CW;

   always_comb begin
      nt_addr   = NT_BASE | AW'({cur.vs, cur.hs, cur.cv, cur.ch});
      at_addr   = NT_BASE | AW'({cur.vs, cur.hs, {TSEL{1'b0}}}) | AW'(ATTR_OFS)
                | AW'({cur.cv[CW-1:CW-3], cur.ch[CW-1:CW-3]});
      port_addr = {cur.fv[1:0], cur.vs, cur.hs, cur.cv, cur.ch};
      pt_addr   = AW'({bg_sel, tile_idx, 1'b0, cur.fv});
   end
endmodule

// File: rtl/scroll_ctr_unit.sv
module scroll_ctr_unit
   import scrl_pkg::*;
#(
   parameter int          ROW_WRAP = 30,
   parameter int          TILE_W   = 8,
   parameter logic [13:0] NT_BASE  = 14'h2000,
   parameter logic [9:0]  ATTR_OFS = 10'h3C0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tmp_wr,
   input  logic [SW-1:0]     tmp_in,
   input  logic              fh_wr,
   input  logic [FW-1:0]     fh_in,
   input  logic              tmp_clr,
   input  logic              copy_all,
   input  logic              copy_h,
   input  logic              step_h,
   input  logic              step_v,
   input  logic              step_port,
   input  logic              port_by32,
   input  logic              bg_sel,
   input  logic [TILE_W-1:0] tile_idx,
   output logic [AW-1:0]     nt_addr,
   output logic [AW-1:0]     at_addr,
   output logic [AW-1:0]     pt_addr,
   output logic [AW-1:0]     port_addr,
   output logic [FW-1:0]     fine_h
);
   generate
      if (ROW_WRAP < 2 || ROW_WRAP > (1 << CW)) begin : g_bad_wrap
         $error("ROW_WRAP out of range");
      end
      if (TILE_W + FW + 2 > AW) begin : g_bad_tile
         $error("TILE_W too wide for pattern address");
      end
   endgenerate

   scrl_set_t live_q, tmp_q, live_d;
   scrl_set_t h_nxt, v_nxt, p_nxt, hv_nxt;
   logic [FW-1:0] fh_q;

   scrl_hchain u_h (.cur(live_q), .nxt(h_nxt));
   scrl_vchain #(.ROW_WRAP(ROW_WRAP)) u_v (.cur(live_q), .nxt(v_nxt));
   scrl_portinc u_p (.cur(live_q), .by32(port_by32), .nxt(p_nxt));

   // Column and row steps touch disjoint fields, so both may apply at once.
   always_comb begin
      hv_nxt = live_q;
      if (step_h) begin
         hv_nxt.hs = h_nxt.hs;
         hv_nxt.ch = h_nxt.ch;
      end
      if (step_v) begin
         hv_nxt.fv = v_nxt.fv;
         hv_nxt.vs = v_nxt.vs;
         hv_nxt.cv = v_nxt.cv;
      end
   end

   always_comb begin
      live_d = live_q;
      if (copy_all) begin
         live_d = tmp_q;
      end else if (copy_h) begin
         live_d.hs = tmp_q.hs;
         live_d.ch = tmp_q.ch;
      end else if (step_port) begin
         live_d = p_nxt;
      end else begin
         live_d = hv_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= '0;
         tmp_q  <= '0;
         fh_q   <= '0;
      end else begin
         live_q <= live_d;
         if (tmp_clr) begin
            tmp_q <= '0;
            fh_q  <= '0;
         end else begin
            if (tmp_wr) tmp_q <= scrl_set_t'(tmp_in);
            if (fh_wr)  fh_q  <= fh_in;
         end
      end
   end

   assign fine_h = fh_q;

   scrl_addrgen #(
      .TILE_W(TILE_W), .NT_BASE(NT_BASE), .ATTR_OFS(ATTR_OFS)
   ) u_a (
      .cur(live_q), .bg_sel(bg_sel), .tile_idx(tile_idx),
      .nt_addr(nt_addr), .at_addr(at_addr), .pt_addr(pt_addr), .port_addr(port_addr)
   );
endmodule

// File: rtl/scroll_ctr_chk.sv
module scroll_ctr_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        tmp_clr,
   input logic        copy_all,
   input logic        copy_h,
   input logic        step_h,
   input logic        step_v,
   input logic        step_port,
   input logic        port_by32,
   input logic [13:0] nt_addr,
   input logic [13:0] at_addr,
   input logic [13:0] pt_addr,
   input logic [13:0] port_addr,
   input logic [2:0]  fine_h
);
   logic no_copy;
   assign no_copy = !copy_all && !copy_h;

   a_r2_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (no_copy && !step_port && step_h && port_addr[4:0] == 5'd31)
      |=> (port_addr[4:0] == 5'd0 && port_addr[10] != $past(port_addr[10])));

   a_r3_fine_step: assert property (@(posedge clk) disable iff (!rst_n)
      (no_copy && !step_port && step_v && !step_h && pt_addr[2:0] != 3'd7)
      |=> (pt_addr[2:0] == $past(pt_addr[2:0]) + 3'd1 && port_addr[11:0] == $past(port_addr[11:0])));

   a_r5_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (no_copy && step_port && port_by32) |=> (port_addr[4:0] == $past(port_addr[4:0])));

   a_r8_hcopy_keeps_vert: assert property (@(posedge clk) disable iff (!rst_n)
      (!copy_all && copy_h)
      |=> (port_addr[13:11] == $past(port_addr[13:11]) && port_addr[9:5] == $past(port_addr[9:5])));

   a_r9_clear_fine: assert property (@(posedge clk) disable iff (!rst_n)
      tmp_clr |=> (fine_h == 3'd0));

   a_r6_tables_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (nt_addr[11:0] == port_addr[11:0] && at_addr[13:10] == nt_addr[13:10] && at_addr[9:6] == 4'hF));
endmodule

bind scroll_ctr_unit scroll_ctr_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tmp_clr(tmp_clr), .copy_all(copy_all), .copy_h(copy_h),
   .step_h(step_h), .step_v(step_v), .step_port(step_port), .port_by32(port_by32),
   .nt_addr(nt_addr), .at_addr(at_addr), .pt_addr(pt_addr), .port_addr(port_addr),
   .fine_h(fine_h)
);

// File: tb/sim_scroll_ctr_unit.sv
module sim_scroll_ctr_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tmp_wr = 0, fh_wr = 0, tmp_clr = 0, copy_all = 0, copy_h = 0;
   logic        step_h = 0, step_v = 0, step_port = 0, port_by32 = 0, bg_sel = 0;
   logic [14:0] tmp_in = '0;
   logic [2:0]  fh_in = '0;
   logic [7:0]  tile_idx = '0;
   logic [13:0] nt_addr, at_addr, pt_addr, port_addr;
   logic [2:0]  fine_h;
   int total = 0, bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   scroll_ctr_unit u0 (
      .clk(clk), .rst_n(rst_n), .tmp_wr(tmp_wr), .tmp_in(tmp_in), .fh_wr(fh_wr), .fh_in(fh_in),
      .tmp_clr(tmp_clr), .copy_all(copy_all), .copy_h(copy_h), .step_h(step_h), .step_v(step_v),
      .step_port(step_port), .port_by32(port_by32), .bg_sel(bg_sel), .tile_idx(tile_idx),
      .nt_addr(nt_addr), .at_addr(at_addr), .pt_addr(pt_addr), .port_addr(port_addr), .fine_h(fine_h)
   );

   function automatic logic [13:0] e_port(int fv, int v, int h, int vt, int ht);
      return 14'(((fv & 3) << 12) | (v << 11) | (h << 10) | (vt << 5) | ht);
   endfunction
   function automatic logic [13:0] e_nt(int v, int h, int vt, int ht);
      return 14'(32'h2000 | (v << 11) | (h << 10) | (vt << 5) | ht);
   endfunction
   function automatic logic [13:0] e_at(int v, int h, int vt, int ht);
      return 14'(32'h2000 | (v << 11) | (h << 10) | 32'h3C0 | ((vt >> 2) << 3) | (ht >> 2));
   endfunction

   task automatic chk(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   // Check full live state: port address plus full FV from the pattern address.
   task automatic chk_state(input string tag, input int fv, input int v, input int h, input int vt, input int ht);
      chk({tag, " port"}, port_addr, e_port(fv, v, h, vt, ht));
      chk({tag, " fv"}, pt_addr[2:0], fv);
   endtask

   task automatic stage(input int fv, input int v, input int h, input int vt, input int ht);
      @(negedge clk);
      tmp_in = 15'((fv << 12) | (v << 11) | (h << 10) | (vt << 5) | ht);
      tmp_wr = 1;
      @(negedge clk);
      tmp_wr = 0;
   endtask

   task automatic load(input int fv, input int v, input int h, input int vt, input int ht);
      stage(fv, v, h, vt, ht);
      copy_all = 1;
      @(negedge clk);
      copy_all = 0;
   endtask

   task automatic pulse(input bit a_all, input bit a_h, input bit a_sh, input bit a_sv,
                        input bit a_sp, input bit a_32);
      @(negedge clk);
      copy_all = a_all; copy_h = a_h; step_h = a_sh; step_v = a_sv;
      step_port = a_sp; port_by32 = a_32;
      @(negedge clk);
      copy_all = 0; copy_h = 0; step_h = 0; step_v = 0; step_port = 0; port_by32 = 0;
   endtask

   task automatic t_reset;
      chk("R1 nt", nt_addr, 14'h2000);
      chk("R1 at", at_addr, 14'h23C0);
      chk("R1 port", port_addr, 0);
      chk("R1 pt", pt_addr, 0);
      chk("R1 fine_h", fine_h, 0);
      copy_all = 1; @(negedge clk); copy_all = 0;
      chk("R1 staged zero", port_addr, 0);
   endtask

   task automatic t_col;
      load(2, 0, 0, 7, 30);
      pulse(0, 0, 1, 0, 0, 0); chk_state("R2 step", 2, 0, 0, 7, 31);
      pulse(0, 0, 1, 0, 0, 0); chk_state("R2 carry into H", 2, 0, 1, 7, 0);
      load(5, 1, 1, 12, 31);
      pulse(0, 0, 1, 0, 0, 0); chk_state("R2 H toggles back", 5, 1, 0, 12, 0);
   endtask

   task automatic t_row;
      load(6, 0, 0, 4, 3);
      pulse(0, 0, 0, 1, 0, 0); chk_state("R3 fine step", 7, 0, 0, 4, 3);
      pulse(0, 0, 0, 1, 0, 0); chk_state("R3 carry to VT", 0, 0, 0, 5, 3);
      load(7, 0, 1, 29, 3);
      pulse(0, 0, 0, 1, 0, 0); chk_state("R3 row 29 wraps", 0, 1, 1, 0, 3);
      load(7, 1, 0, 31, 0);
      pulse(0, 0, 0, 1, 0, 0); chk_state("R3 row 31 no toggle", 0, 1, 0, 0, 0);
      load(7, 1, 0, 30, 0);
      pulse(0, 0, 0, 1, 0, 0); chk_state("R3 row 30 to 31", 0, 1, 0, 31, 0);
   endtask

   task automatic t_port1;
      load(0, 0, 0, 0, 31);
      pulse(0, 0, 0, 0, 1, 0); chk_state("R4 HT into VT", 0, 0, 0, 1, 0);
      load(0, 0, 0, 31, 31);
      pulse(0, 0, 0, 0, 1, 0); chk_state("R4 VT into H", 0, 0, 1, 0, 0);
      load(3, 1, 1, 31, 31);
      pulse(0, 0, 0, 0, 1, 0); chk_state("R4 V into FV", 4, 0, 0, 0, 0);
      load(7, 1, 1, 31, 31);
      pulse(0, 0, 0, 0, 1, 0); chk_state("R4 full rollover", 0, 0, 0, 0, 0);
   endtask

   task automatic t_port32;
      load(0, 0, 0, 31, 5);
      pulse(0, 0, 0, 0, 1, 1); chk_state("R5 VT into H", 0, 0, 1, 0, 5);
      load(1, 1, 1, 31, 9);
      pulse(0, 0, 0, 0, 1, 1); chk_state("R5 chain to FV", 2, 0, 0, 0, 9);
      load(0, 0, 0, 3, 31);
      pulse(0, 0, 0, 0, 1, 1); chk_state("R5 HT held", 0, 0, 0, 4, 31);
   endtask

   task automatic t_addr;
      bg_sel = 1; tile_idx = 8'hA7;
      load(5, 1, 0, 22, 13);
      chk("R6 nt", nt_addr, 14'h2ACD);
      chk("R6 at", at_addr, 14'h2BEB);
      chk("R7 port", port_addr, 14'h1ACD);
      chk("R7 pt", pt_addr, 14'h1A75);
      load(2, 0, 1, 31, 30);
      chk("R6 nt b", nt_addr, e_nt(0, 1, 31, 30));
      chk("R6 at b", at_addr, e_at(0, 1, 31, 30));
      bg_sel = 0; tile_idx = 8'h3C;
      @(negedge clk);
      chk("R7 pt b", pt_addr, 14'h03C2);
   endtask

   task automatic t_copy;
      load(4, 1, 1, 9, 17);
      stage(0, 0, 0, 2, 3);
      pulse(0, 1, 0, 0, 0, 0); chk_state("R8 copy_h", 4, 1, 0, 9, 3);
      pulse(1, 0, 0, 0, 0, 0); chk_state("R8 copy_all", 0, 0, 0, 2, 3);
   endtask

   task automatic t_clear;
      @(negedge clk); fh_in = 5; fh_wr = 1;
      @(negedge clk); fh_wr = 0;
      chk("R11 fine_h load", fine_h, 5);
      stage(3, 1, 1, 8, 8);
      @(negedge clk);
      tmp_clr = 1; tmp_wr = 1; tmp_in = 15'h7FFF; fh_wr = 1; fh_in = 6;
      @(negedge clk);
      tmp_clr = 0; tmp_wr = 0; fh_wr = 0;
      chk("R9 fine_h cleared", fine_h, 0);
      pulse(1, 0, 0, 0, 0, 0); chk_state("R9 staged cleared", 0, 0, 0, 0, 0);
   endtask

   task automatic t_prio;
      load(1, 0, 0, 3, 3);
      stage(2, 1, 1, 4, 4);
      pulse(1, 0, 1, 1, 1, 0); chk_state("R10 copy_all wins", 2, 1, 1, 4, 4);
      stage(0, 0, 0, 0, 9);
      pulse(0, 1, 1, 1, 0, 0); chk_state("R10 copy_h wins", 2, 1, 0, 4, 9);
      pulse(0, 0, 1, 1, 1, 0); chk_state("R10 port wins", 2, 1, 0, 4, 10);
      pulse(0, 0, 1, 1, 0, 0); chk_state("R10 h and v together", 3, 1, 0, 4, 11);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_col;
      t_row;
      t_port1;
      t_port32;
      t_addr;
      t_copy;
      t_clear;
      t_prio;
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule